// File: doc/BRIEF.md
# Segment Access Bounds Checker

This block decides whether one memory access made through a cached segment is legal. The caller presents the segment attributes already held in the segment cache: a 20-bit raw limit, a granularity flag, a big flag, an expand-down flag, a code/data flag and one permission bit. The permission bit means "readable" for code segments and "writable" for data segments. Along with these it presents the 32-bit offset, the access width and the read/write kind, and raises a request strobe. One clock later the block returns the effective 32-bit limit and a general-protection fault flag.

A second mode checks a descriptor-table index against a table limit. Each entry occupies 8 bytes, and the limit names the last valid byte of the table. The sequencing is a two-state machine. `ST_IDLE` moves to `ST_RESP` on a request. `ST_RESP` stays in `ST_RESP` while requests keep arriving back to back, and returns to `ST_IDLE` when the strobe is low. `rsp_valid` is high exactly while the machine is in `ST_RESP`.

Top module: `seg_bounds_chk`

## Requirements
- R1: After reset `rsp_valid` and `gp_fault` are 0 and `eff_limit` is 0.
- R2: A request sampled on a clock edge gives `rsp_valid`=1 with that request's result in the following cycle, including on back-to-back requests. In a cycle that follows an edge with no request, `rsp_valid` and `gp_fault` are both 0.
- R3: With `gran`=0 the effective limit is the raw limit zero-extended. With `gran`=1 it is the raw limit shifted left by 12 with the low 12 bits set to one.
- R4: `acc_size` encodes 0 as byte, 1 as word, and 2 or 3 as doubleword. For an expand-up segment the access faults when its last byte (offset + width - 1) exceeds the effective limit.
- R5: The last-byte sum is formed in 33 bits, so an access that wraps past 0xFFFFFFFF faults even when the limit is 0xFFFFFFFF.
- R6: For an expand-down data segment the access faults when its offset is less than or equal to the effective limit.
- R7: For an expand-down data segment the upper bound for the last byte is 0xFFFF when `big`=0 and 0xFFFFFFFF when `big`=1.
- R8: An expand-down segment with limit 0 accepts every offset from 1 up to its upper bound.
- R9: For code segments (`is_code`=1) the expand-down flag has no effect, and the segment is bounded as expand-up.
- R10: A write (`acc_write`=1) faults when the target is a code segment, or a data segment with `perm_bit`=0.
- R11: A read faults on a code segment with `perm_bit`=0. Reads of data segments never fault on type.
- R12: In table mode (`tbl_mode`=1) the access faults exactly when `tbl_index`*8+7 exceeds the effective limit. In this mode the access width, kind and type flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Check request strobe |
| tbl_mode | input | 1 | 1 selects descriptor-table index check |
| raw_limit | input | 20 | Raw limit field |
| gran | input | 1 | Granularity flag |
| big | input | 1 | Big flag (expand-down upper bound) |
| exp_down | input | 1 | Expand-down flag |
| is_code | input | 1 | 1 for executable segment |
| perm_bit | input | 1 | Readable (code) or writable (data) |
| offset | input | 32 | Access offset |
| tbl_index | input | 13 | Descriptor-table index |
| acc_size | input | 2 | Access width code |
| acc_write | input | 1 | 1 for write, 0 for read |
| eff_limit | output | 32 | Registered effective limit |
| rsp_valid | output | 1 | Result valid |
| gp_fault | output | 1 | Registered protection fault |

## Verification
The hardest cases to reach from the ports are accesses whose last byte crosses the top of the 32-bit space. A plain 32-bit sum would wrap there and slip under the limit. The bench reaches these cases by setting a raw limit of 0xFFFFF with granularity on, which gives an effective limit of 0xFFFFFFFF, and then placing word and doubleword accesses one to three bytes below the top. It also drives back-to-back strobes that carry opposite expected outcomes, to show each response belongs to the request just before it.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } chk_state_e;

    // Number of bytes beyond the first touched by an access.
    function automatic logic [1:0] span_minus_one(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: span_minus_one = 2'd0;
            SZ_WORD: span_minus_one = 2'd1;
            default: span_minus_one = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/seg_limit_expand.sv
module seg_limit_expand #(
    parameter int RAW_W   = 20,
    parameter int ADDR_W  = 32,
    parameter int GRAN_SH = 12
) (
    input  logic [RAW_W-1:0]  raw_limit,
    input  logic              gran,
    output logic [ADDR_W-1:0] limit_out
);
    localparam int COARSE_W = RAW_W + GRAN_SH;

    logic [ADDR_W-1:0] fine_lim;
    logic [ADDR_W-1:0] coarse_lim;

    generate
        if (COARSE_W >= ADDR_W) begin : g_trunc
            logic [COARSE_W-1:0] coarse_full;
            assign coarse_full = {raw_limit, {GRAN_SH{1'b1}}};
            assign coarse_lim  = coarse_full[ADDR_W-1:0];
        end else begin : g_pad
            assign coarse_lim = {{(ADDR_W-COARSE_W){1'b0}}, raw_limit, {GRAN_SH{1'b1}}};
        end
    endgenerate

    assign fine_lim  = ADDR_W'(raw_limit);
    assign limit_out = gran ? coarse_lim : fine_lim;

endmodule

// File: rtl/seg_range_judge.sv
module seg_range_judge #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 13,
    parameter int SMALL_W = 16
) (
    input  logic [ADDR_W-1:0] eff_limit,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        acc_size,
    input  logic              exp_down,
    input  logic              big,
    input  logic              tbl_mode,
    input  logic [IDX_W-1:0]  tbl_index,
    output logic              range_fault
);
    import segchk_pkg::*;

    localparam int EXT_W    = ADDR_W + 1;
    localparam int ENTRY_SH = 3;

    logic [EXT_W-1:0] lim_x;
    logic [EXT_W-1:0] first_x;
    logic [EXT_W-1:0] last_x;
    logic [EXT_W-1:0] top_x;
    logic [EXT_W-1:0] ent_first;
    logic [EXT_W-1:0] ent_last;

    always_comb begin
        lim_x     = {1'b0, eff_limit};
        first_x   = {1'b0, offset};
        last_x    = first_x + EXT_W'(span_minus_one(acc_size));
        top_x     = big ? {1'b0, {ADDR_W{1'b1}}} : EXT_W'({SMALL_W{1'b1}});
        ent_first = EXT_W'({tbl_index, {ENTRY_SH{1'b0}}});
        ent_last  = ent_first + EXT_W'((1 << ENTRY_SH) - 1);
        if (tbl_mode) begin
            range_fault = ent_last > lim_x;
        end else if (exp_down) begin
            range_fault = (first_x <= lim_x) || (last_x > top_x);
        end else begin
            range_fault = last_x > lim_x;
        end
    end

endmodule

// File: rtl/seg_type_judge.sv
module seg_type_judge (
    input  logic is_code,
    input  logic perm_bit,
    input  logic acc_write,
    output logic type_fault
);
    always_comb begin
        if (acc_write) begin
            type_fault = is_code || !perm_bit;
        end else begin
            type_fault = is_code && !perm_bit;
        end
    end
endmodule

// File: rtl/seg_bounds_chk.sv
module seg_bounds_chk #(
    parameter int RAW_W   = 20,
    parameter int ADDR_W  = 32,
    parameter int GRAN_SH = 12,
    parameter int IDX_W   = 13,
    parameter int SMALL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              tbl_mode,
    input  logic [RAW_W-1:0]  raw_limit,
    input  logic              gran,
    input  logic              big,
    input  logic              exp_down,
    input  logic              is_code,
    input  logic              perm_bit,
    input  logic [ADDR_W-1:0] offset,
    input  logic [IDX_W-1:0]  tbl_index,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    output logic [ADDR_W-1:0] eff_limit,
    output logic              rsp_valid,
    output logic              gp_fault
);
    import segchk_pkg::*;

    chk_state_e        state_q, state_d;
    logic [ADDR_W-1:0] lim_c;
    logic              range_flt;
    logic              type_flt;
    logic              down_eff;
    logic              fault_c;

    seg_limit_expand #(
        .RAW_W  (RAW_W),
        .ADDR_W (ADDR_W),
        .GRAN_SH(GRAN_SH)
    ) u_expand (
        .raw_limit(raw_limit),
        .gran     (gran),
        .limit_out(lim_c)
    );

    // Expand-down is meaningful for data segments only.
    assign down_eff = exp_down && !is_code;

    seg_range_judge #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .SMALL_W(SMALL_W)
    ) u_range (
        .eff_limit  (lim_c),
        .offset     (offset),
        .acc_size   (acc_size),
        .exp_down   (down_eff),
        .big        (big),
        .tbl_mode   (tbl_mode),
        .tbl_index  (tbl_index),
        .range_fault(range_flt)
    );

    seg_type_judge u_type (
        .is_code   (is_code),
        .perm_bit  (perm_bit),
        .acc_write (acc_write),
        .type_fault(type_flt)
    );

    assign fault_c = tbl_mode ? range_flt : (range_flt || type_flt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_limit <= '0;
            gp_fault  <= 1'b0;
        end else if (req_valid) begin
            eff_limit <= lim_c;
            gp_fault  <= fault_c;
        end else begin
            gp_fault  <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !gp_fault)); // R2
    AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> rsp_valid); // R2
    AST_CODE_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tbl_mode && acc_write && is_code) |=> gp_fault); // R10
    AST_GRAN_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && gran) |=> (eff_limit[GRAN_SH-1:0] == {GRAN_SH{1'b1}})); // R3
    AST_TBL_IGNORES_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tbl_mode && !gran && raw_limit == '1 && tbl_index == '0) |=> !gp_fault); // R12

endmodule

// File: tb/seg_bounds_chk_bench.sv
module seg_bounds_chk_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        tbl_mode = 1'b0;
    logic [19:0] raw_limit = '0;
    logic        gran = 1'b0;
    logic        big = 1'b0;
    logic        exp_down = 1'b0;
    logic        is_code = 1'b0;
    logic        perm_bit = 1'b0;
    logic [31:0] offset = '0;
    logic [12:0] tbl_index = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0;
    logic [31:0] eff_limit;
    logic        rsp_valid;
    logic        gp_fault;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    seg_bounds_chk u_seg_bounds_chk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tbl_mode(tbl_mode),
        .raw_limit(raw_limit), .gran(gran), .big(big), .exp_down(exp_down),
        .is_code(is_code), .perm_bit(perm_bit), .offset(offset),
        .tbl_index(tbl_index), .acc_size(acc_size), .acc_write(acc_write),
        .eff_limit(eff_limit), .rsp_valid(rsp_valid), .gp_fault(gp_fault)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic set_seg(input logic [19:0] lim, input logic g, input logic b,
                           input logic dn, input logic code, input logic pb);
        raw_limit = lim; gran = g; big = b; exp_down = dn; is_code = code; perm_bit = pb;
    endtask

    // One request, result sampled on the next falling edge.
    task automatic probe(input string tag, input logic [31:0] off, input logic [1:0] sz,
                         input logic wr, input logic exp_f);
        @(negedge clk);
        tbl_mode = 1'b0; offset = off; acc_size = sz; acc_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(gp_fault), 32'(exp_f));
    endtask

    task automatic t_reset_r1();
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 gp_fault", 32'(gp_fault), 32'd0);
        chk("R1 eff_limit", eff_limit, 32'd0);
    endtask

    task automatic t_gran_r3();
        set_seg(20'h12345, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R3 fine", 32'h0, 2'd0, 1'b0, 1'b0);
        chk("R3 fine limit", eff_limit, 32'h00012345);
        set_seg(20'h12345, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R3 coarse", 32'h0, 2'd0, 1'b0, 1'b0);
        chk("R3 coarse limit", eff_limit, 32'h12345FFF);
    endtask

    task automatic t_up_r4();
        set_seg(20'h00100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R4 byte at lim", 32'h100, 2'd0, 1'b0, 1'b0);
        probe("R4 byte past", 32'h101, 2'd0, 1'b0, 1'b1);
        probe("R4 word ok", 32'h0FF, 2'd1, 1'b0, 1'b0);
        probe("R4 word at lim", 32'h100, 2'd1, 1'b0, 1'b1);
        probe("R4 dword ok", 32'h0FD, 2'd2, 1'b1, 1'b0);
        probe("R4 dword over", 32'h0FE, 2'd2, 1'b0, 1'b1);
        probe("R4 size3 over", 32'h0FE, 2'd3, 1'b0, 1'b1);
    endtask

    task automatic t_wrap_r5();
        set_seg(20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R5 dword top", 32'hFFFFFFFC, 2'd2, 1'b0, 1'b0);
        probe("R5 dword wrap", 32'hFFFFFFFD, 2'd2, 1'b0, 1'b1);
        probe("R5 word wrap", 32'hFFFFFFFF, 2'd1, 1'b0, 1'b1);
        probe("R5 byte top", 32'hFFFFFFFF, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_down_r6_r7();
        set_seg(20'h00FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        probe("R6 at lim", 32'h0FFF, 2'd0, 1'b0, 1'b1);
        probe("R6 above lim", 32'h1000, 2'd0, 1'b1, 1'b0);
        probe("R7 small word ok", 32'hFFFE, 2'd1, 1'b0, 1'b0);
        probe("R7 small word over", 32'hFFFF, 2'd1, 1'b0, 1'b1);
        probe("R7 small dword ok", 32'hFFFC, 2'd2, 1'b0, 1'b0);
        set_seg(20'h00FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R7 big byte", 32'h10000, 2'd0, 1'b0, 1'b0);
        probe("R7 big dword ok", 32'hFFFFFFFC, 2'd2, 1'b0, 1'b0);
        probe("R7 big dword wrap", 32'hFFFFFFFD, 2'd2, 1'b0, 1'b1);
    endtask

    task automatic t_down_zero_r8();
        set_seg(20'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R8 offset0", 32'h0, 2'd0, 1'b0, 1'b1);
        probe("R8 offset1", 32'h1, 2'd0, 1'b0, 1'b0);
        probe("R8 top byte", 32'hFFFFFFFF, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_code_r9();
        set_seg(20'h00FFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        probe("R9 low read", 32'h10, 2'd0, 1'b0, 1'b0);
        probe("R9 past lim", 32'h1000, 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_write_r10();
        set_seg(20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        probe("R10 write code", 32'h10, 2'd0, 1'b1, 1'b1);
        set_seg(20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        probe("R10 write ro data", 32'h10, 2'd0, 1'b1, 1'b1);
        set_seg(20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R10 write rw data", 32'h10, 2'd0, 1'b1, 1'b0);
    endtask

    task automatic t_read_r11();
        set_seg(20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        probe("R11 read exec-only", 32'h10, 2'd0, 1'b0, 1'b1);
        set_seg(20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        probe("R11 read ro data", 32'h10, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic tbl_probe(input string tag, input logic [12:0] idx, input logic exp_f);
        @(negedge clk);
        tbl_mode = 1'b1; tbl_index = idx; offset = 32'hFFFFFFFF; acc_size = 2'd2;
        acc_write = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(gp_fault), 32'(exp_f));
    endtask

    task automatic t_table_r12();
        set_seg(20'h00017, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        tbl_probe("R12 last entry", 13'd2, 1'b0);
        tbl_probe("R12 beyond", 13'd3, 1'b1);
        set_seg(20'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tbl_probe("R12 coarse idx511", 13'd511, 1'b0);
        tbl_probe("R12 coarse idx512", 13'd512, 1'b1);
        tbl_mode = 1'b0;
    endtask

    task automatic t_b2b_r2();
        set_seg(20'h00100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        tbl_mode = 1'b0; acc_size = 2'd0; acc_write = 1'b0;
        offset = 32'h200; req_valid = 1'b1;
        @(negedge clk);
        chk("R2 first valid", 32'(rsp_valid), 32'd1);
        chk("R2 first fault", 32'(gp_fault), 32'd1);
        offset = 32'h010;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 second valid", 32'(rsp_valid), 32'd1);
        chk("R2 second fault", 32'(gp_fault), 32'd0);
        offset = 32'h200;
        @(negedge clk);
        chk("R2 idle valid", 32'(rsp_valid), 32'd0);
        chk("R2 idle fault", 32'(gp_fault), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        t_gran_r3();
        t_up_r4();
        t_wrap_r5();
        t_down_r6_r7();
        t_down_zero_r8();
        t_code_r9();
        t_write_r10();
        t_read_r11();
        t_table_r12();
        t_b2b_r2();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule